// File: doc/BRIEF.md
# Coherent cache line state controller

This block holds the coherence state of every line in a small direct-mapped requester cache. Each line is in one of five states, built from two independent properties: clean or dirty, and unique or shared. The block sits between the core-side lookup logic, the outbound request channel and the inbound snoop channel. Line data is kept elsewhere. The block only decides states, request types and snoop reply flags.

A local access is a load (normal, not-shared-dirty, or one-shot) or a store (partial or full line). A hit that needs no permission finishes at once. Any other access issues one request, and the block records that request as outstanding. When a conflicting line has to leave the slot, the block emits a victim notice in the same cycle: a write-back if the line is dirty, or a data-less eviction notice if it is clean.

The completion response carries two flags, ownership-passed and may-be-shared. The block combines these flags with the outstanding request type to set the final line state. A snoop gets a registered reply one cycle after it is accepted. The reply says whether data is returned, whether write-back responsibility moves with it, and whether a copy stays behind. A snoop or a local access that targets the slot of an outstanding request waits until the completion has been taken.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `req_valid`, `vic_valid` and `rsp_valid` are 0, and `loc_ready` and `snp_ready` are 1.
- R2: A load miss issues one request in the cycle after acceptance, with `req_addr` equal to the line address. The request type depends on `loc_op`: normal load (0) issues ReadShared (`req_type` 0), not-shared-dirty load (1) issues ReadNotSharedDirty (1), and one-shot load (2) issues ReadOnce (2). A load hit in any valid state sets `loc_hit` and issues nothing.
- R3: A ReadShared fill sets the state from the flags: ownership-passed makes the line dirty, and may-be-shared makes it shared. A ReadNotSharedDirty fill never ends SharedDirty: ownership-passed gives UniqueDirty, otherwise may-be-shared gives SharedClean and no flags give UniqueClean.
- R4: A ReadOnce fill never allocates the line, so the same line stays absent to later loads and snoops.
- R5: A partial store (`loc_op` 3) that misses issues ReadUnique (3). A partial store to a line held Shared issues CleanUnique (4). A full-line store (`loc_op` 4) to a line not held Unique issues MakeUnique (5). Each of these ends UniqueDirty on completion.
- R6: A store that hits a UniqueClean line makes it UniqueDirty. A store that hits a UniqueDirty line leaves it UniqueDirty. Neither issues a request, and both set `loc_hit`.
- R7: A snoop reply appears exactly one cycle after acceptance. A snoop to an absent line returns no data, both flags are 0, and no state changes.
- R8: A ReadShared snoop (`snp_type` 1) to a present line returns data with may-be-shared set, and the line moves UniqueDirty to SharedDirty and UniqueClean to SharedClean. A ReadOnce snoop (0) returns data with may-be-shared set and leaves the state as it was.
- R9: A ReadUnique (2), CleanInvalid (3) or MakeInvalid (4) snoop leaves the line Invalid. If the line was dirty, the reply carries data with ownership-passed set. ReadUnique also returns data for a clean line.
- R10: A CleanShared snoop (5) to a dirty line returns data with ownership-passed and may-be-shared set. The line becomes clean and keeps its uniqueness.
- R11: While a request is outstanding, a snoop to the same slot (`addr[IDX_W-1:0]`) is held with `snp_ready` 0 until the cycle after the completion. A local access to that slot, or any local access that needs a request, is stalled with `loc_ready` 0. Hits to other slots still proceed.
- R12: A miss that allocates into a slot holding a different valid line sets `vic_valid` together with `req_valid`, with `vic_addr` equal to the old line address. `vic_dirty` is 1 (write-back) for a dirty victim and 0 (data-less eviction) for a clean one.
- R13: When a snoop and a local access target the same slot in the same cycle, the snoop is accepted and the local access is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local access present |
| loc_op | input | 3 | 0 load, 1 load not-shared-dirty, 2 load one-shot, 3 partial store, 4 full-line store |
| loc_addr | input | ADDR_W | Line address of the local access |
| loc_ready | output | 1 | Local access can be taken this cycle |
| loc_hit | output | 1 | Local access finishes without a request |
| req_valid | output | 1 | Request issued (one cycle) |
| req_type | output | 3 | Request type code, see R2 and R5 |
| req_addr | output | ADDR_W | Line address of the request |
| vic_valid | output | 1 | Victim leaves the slot |
| vic_dirty | output | 1 | 1 write-back, 0 data-less eviction |
| vic_addr | output | ADDR_W | Line address of the victim |
| cmp_valid | input | 1 | Completion of the outstanding request |
| cmp_pass_dirty | input | 1 | Write-back responsibility passed to the requester |
| cmp_is_shared | input | 1 | Another cache may hold the line |
| snp_valid | input | 1 | Snoop present |
| snp_type | input | 3 | Snoop type code, see R8 to R10 |
| snp_addr | input | ADDR_W | Line address of the snoop |
| snp_ready | output | 1 | Snoop can be taken this cycle |
| rsp_valid | output | 1 | Snoop reply valid |
| rsp_data | output | 1 | Reply carries line data |
| rsp_pass_dirty | output | 1 | Reply passes write-back responsibility |
| rsp_is_shared | output | 1 | Snooped cache keeps a copy |

## Verification
The hardest situation to create is the hazard window. A request has to be outstanding while a snoop and local accesses to both the same slot and other slots are presented. The completion must then arrive while the snoop is still held. The stimulus issues a miss and withholds the completion. It holds a snoop to that slot and probes the stall rules one after another within a single cycle. It then raises the completion while the snoop waits and checks that the reply appears only after the release. Dirty and shared fill states cannot be seen directly, so they are read back through CleanShared snoops and through whether a later store hits or needs an upgrade.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        ST_I  = 3'd0,
        ST_UC = 3'd1,
        ST_UD = 3'd2,
        ST_SC = 3'd3,
        ST_SD = 3'd4
    } line_st_e;

    typedef enum logic [2:0] {
        OP_LD      = 3'd0,
        OP_LD_NSD  = 3'd1,
        OP_LD_ONCE = 3'd2,
        OP_ST      = 3'd3,
        OP_ST_FULL = 3'd4
    } loc_op_e;

    typedef enum logic [2:0] {
        RQ_RD_SHARED    = 3'd0,
        RQ_RD_NSD       = 3'd1,
        RQ_RD_ONCE      = 3'd2,
        RQ_RD_UNIQUE    = 3'd3,
        RQ_CLEAN_UNIQUE = 3'd4,
        RQ_MAKE_UNIQUE  = 3'd5
    } req_e;

    typedef enum logic [2:0] {
        SN_ONCE         = 3'd0,
        SN_SHARED       = 3'd1,
        SN_UNIQUE       = 3'd2,
        SN_CLEAN_INV    = 3'd3,
        SN_MAKE_INV     = 3'd4,
        SN_CLEAN_SHARED = 3'd5
    } snp_e;

    function automatic logic st_dirty(line_st_e s);
        return (s == ST_UD) || (s == ST_SD);
    endfunction

    function automatic logic st_unique(line_st_e s);
        return (s == ST_UD) || (s == ST_UC);
    endfunction

endpackage

// File: rtl/coh_local_dec.sv
module coh_local_dec
    import coh_pkg::*;
(
    input  logic     hit,
    input  line_st_e cur_st,
    input  loc_op_e  op,
    output logic     need_req,
    output req_e     rq,
    output logic     alloc,
    output line_st_e nxt_st
);
    always_comb begin
        need_req = 1'b0;
        rq       = RQ_RD_SHARED;
        alloc    = 1'b0;
        nxt_st   = cur_st;
        case (op)
            OP_ST: begin
                if (hit && st_unique(cur_st)) begin
                    nxt_st = ST_UD;
                end else if (hit) begin
                    need_req = 1'b1;
                    rq       = RQ_CLEAN_UNIQUE;
                end else begin
                    need_req = 1'b1;
                    rq       = RQ_RD_UNIQUE;
                    alloc    = 1'b1;
                end
            end
            OP_ST_FULL: begin
                if (hit && st_unique(cur_st)) begin
                    nxt_st = ST_UD;
                end else begin
                    need_req = 1'b1;
                    rq       = RQ_MAKE_UNIQUE;
                    alloc    = !hit;
                end
            end
            OP_LD_ONCE: begin
                if (!hit) begin
                    need_req = 1'b1;
                    rq       = RQ_RD_ONCE;
                end
            end
            OP_LD_NSD: begin
                if (!hit) begin
                    need_req = 1'b1;
                    rq       = RQ_RD_NSD;
                    alloc    = 1'b1;
                end
            end
            default: begin
                if (!hit) begin
                    need_req = 1'b1;
                    rq       = RQ_RD_SHARED;
                    alloc    = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/coh_fill_res.sv
module coh_fill_res
    import coh_pkg::*;
(
    input  req_e     rq,
    input  logic     pass_dirty,
    input  logic     is_shared,
    output logic     keep,
    output line_st_e fin_st
);
    always_comb begin
        keep   = 1'b0;
        fin_st = ST_UD;
        case (rq)
            RQ_RD_SHARED: begin
                if (pass_dirty) fin_st = is_shared ? ST_SD : ST_UD;
                else            fin_st = is_shared ? ST_SC : ST_UC;
            end
            RQ_RD_NSD: begin
                if (pass_dirty)     fin_st = ST_UD;
                else if (is_shared) fin_st = ST_SC;
                else                fin_st = ST_UC;
            end
            RQ_RD_ONCE: begin
                keep   = 1'b1;
                fin_st = ST_I;
            end
            default: fin_st = ST_UD;
        endcase
    end
endmodule

// File: rtl/coh_snoop_dec.sv
module coh_snoop_dec
    import coh_pkg::*;
(
    input  logic     present,
    input  line_st_e cur_st,
    input  snp_e     kind,
    output line_st_e nxt_st,
    output logic     give_data,
    output logic     pass_dirty,
    output logic     keeps_copy
);
    logic dirty;

    always_comb begin
        dirty      = present && st_dirty(cur_st);
        nxt_st     = cur_st;
        give_data  = 1'b0;
        pass_dirty = 1'b0;
        keeps_copy = 1'b0;
        if (present) begin
            case (kind)
                SN_SHARED: begin
                    give_data  = 1'b1;
                    keeps_copy = 1'b1;
                    if (cur_st == ST_UD)      nxt_st = ST_SD;
                    else if (cur_st == ST_UC) nxt_st = ST_SC;
                end
                SN_UNIQUE: begin
                    give_data  = 1'b1;
                    pass_dirty = dirty;
                    nxt_st     = ST_I;
                end
                SN_CLEAN_INV, SN_MAKE_INV: begin
                    give_data  = dirty;
                    pass_dirty = dirty;
                    nxt_st     = ST_I;
                end
                SN_CLEAN_SHARED: begin
                    give_data  = dirty;
                    pass_dirty = dirty;
                    keeps_copy = 1'b1;
                    if (cur_st == ST_UD)      nxt_st = ST_UC;
                    else if (cur_st == ST_SD) nxt_st = ST_SC;
                end
                default: begin
                    give_data  = 1'b1;
                    keeps_copy = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic [2:0]        loc_op,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic              loc_ready,
    output logic              loc_hit,
    output logic              req_valid,
    output logic [2:0]        req_type,
    output logic [ADDR_W-1:0] req_addr,
    output logic              vic_valid,
    output logic              vic_dirty,
    output logic [ADDR_W-1:0] vic_addr,
    input  logic              cmp_valid,
    input  logic              cmp_pass_dirty,
    input  logic              cmp_is_shared,
    input  logic              snp_valid,
    input  logic [2:0]        snp_type,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_ready,
    output logic              rsp_valid,
    output logic              rsp_data,
    output logic              rsp_pass_dirty,
    output logic              rsp_is_shared
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct {
        line_st_e          st  [DEPTH];
        logic [TAG_W-1:0]  tag [DEPTH];
        logic              busy;
        logic [IDX_W-1:0]  m_idx;
        req_e              m_rq;
        logic              req_v;
        req_e              req_t;
        logic [ADDR_W-1:0] req_a;
        logic              vic_v;
        logic              vic_d;
        logic [ADDR_W-1:0] vic_a;
        logic              rsp_v;
        logic              rsp_d;
        logic              rsp_pd;
        logic              rsp_sh;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [IDX_W-1:0] l_idx, s_idx;
    logic [TAG_W-1:0] l_tag, s_tag;
    line_st_e         l_st, s_st;
    logic             l_hit, s_present;

    assign l_idx     = loc_addr[IDX_W-1:0];
    assign l_tag     = loc_addr[ADDR_W-1:IDX_W];
    assign s_idx     = snp_addr[IDX_W-1:0];
    assign s_tag     = snp_addr[ADDR_W-1:IDX_W];
    assign l_st      = r_q.st[l_idx];
    assign s_st      = r_q.st[s_idx];
    assign l_hit     = (l_st != ST_I) && (r_q.tag[l_idx] == l_tag);
    assign s_present = (s_st != ST_I) && (r_q.tag[s_idx] == s_tag);

    logic     ld_need, ld_alloc;
    req_e     ld_rq;
    line_st_e ld_nxt;

    coh_local_dec u_local (
        .hit      (l_hit),
        .cur_st   (l_st),
        .op       (loc_op_e'(loc_op)),
        .need_req (ld_need),
        .rq       (ld_rq),
        .alloc    (ld_alloc),
        .nxt_st   (ld_nxt)
    );

    logic     fl_keep;
    line_st_e fl_st;

    coh_fill_res u_fill (
        .rq         (r_q.m_rq),
        .pass_dirty (cmp_pass_dirty),
        .is_shared  (cmp_is_shared),
        .keep       (fl_keep),
        .fin_st     (fl_st)
    );

    line_st_e sn_nxt;
    logic     sn_data, sn_pd, sn_sh;

    coh_snoop_dec u_snoop (
        .present    (s_present),
        .cur_st     (s_st),
        .kind       (snp_e'(snp_type)),
        .nxt_st     (sn_nxt),
        .give_data  (sn_data),
        .pass_dirty (sn_pd),
        .keeps_copy (sn_sh)
    );

    logic snp_go, loc_go;

    assign snp_ready = !(r_q.busy && (s_idx == r_q.m_idx));
    assign snp_go    = snp_valid && snp_ready;
    assign loc_ready = !((r_q.busy && (ld_need || (l_idx == r_q.m_idx)))
                         || (snp_go && (s_idx == l_idx)));
    assign loc_go    = loc_valid && loc_ready;
    assign loc_hit   = loc_valid && !ld_need;

    always_comb begin
        r_d       = r_q;
        r_d.req_v = 1'b0;
        r_d.vic_v = 1'b0;
        r_d.rsp_v = 1'b0;

        if (cmp_valid && r_q.busy) begin
            r_d.busy = 1'b0;
            if (!fl_keep) r_d.st[r_q.m_idx] = fl_st;
        end

        if (loc_go) begin
            if (ld_need) begin
                r_d.busy  = 1'b1;
                r_d.m_idx = l_idx;
                r_d.m_rq  = ld_rq;
                r_d.req_v = 1'b1;
                r_d.req_t = ld_rq;
                r_d.req_a = loc_addr;
                if (ld_alloc) begin
                    if (l_st != ST_I) begin
                        r_d.vic_v = 1'b1;
                        r_d.vic_d = st_dirty(l_st);
                        r_d.vic_a = {r_q.tag[l_idx], l_idx};
                    end
                    r_d.st[l_idx]  = ST_I;
                    r_d.tag[l_idx] = l_tag;
                end
            end else begin
                r_d.st[l_idx] = ld_nxt;
            end
        end

        if (snp_go) begin
            r_d.rsp_v     = 1'b1;
            r_d.rsp_d     = sn_data;
            r_d.rsp_pd    = sn_pd;
            r_d.rsp_sh    = sn_sh;
            r_d.st[s_idx] = sn_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                r_q.st[i]  <= ST_I;
                r_q.tag[i] <= '0;
            end
            r_q.busy   <= 1'b0;
            r_q.m_idx  <= '0;
            r_q.m_rq   <= RQ_RD_SHARED;
            r_q.req_v  <= 1'b0;
            r_q.req_t  <= RQ_RD_SHARED;
            r_q.req_a  <= '0;
            r_q.vic_v  <= 1'b0;
            r_q.vic_d  <= 1'b0;
            r_q.vic_a  <= '0;
            r_q.rsp_v  <= 1'b0;
            r_q.rsp_d  <= 1'b0;
            r_q.rsp_pd <= 1'b0;
            r_q.rsp_sh <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid      = r_q.req_v;
    assign req_type       = r_q.req_t;
    assign req_addr       = r_q.req_a;
    assign vic_valid      = r_q.vic_v;
    assign vic_dirty      = r_q.vic_d;
    assign vic_addr       = r_q.vic_a;
    assign rsp_valid      = r_q.rsp_v;
    assign rsp_data       = r_q.rsp_d;
    assign rsp_pass_dirty = r_q.rsp_pd;
    assign rsp_is_shared  = r_q.rsp_sh;

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loc_valid,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              loc_ready,
    input logic              loc_hit,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              vic_valid,
    input logic              snp_valid,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_ready,
    input logic              rsp_valid,
    input logic              rsp_data,
    input logic              rsp_pass_dirty
);
    localparam int IDX_W = $clog2(DEPTH);

    AST_SNOOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && snp_valid && snp_addr[IDX_W-1:0] == req_addr[IDX_W-1:0]) |-> !snp_ready); // R11

    AST_LOCAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && loc_valid && loc_addr[IDX_W-1:0] == req_addr[IDX_W-1:0]) |-> !loc_ready); // R11

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R11

    AST_RSP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready) |=> rsp_valid); // R7

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && snp_ready) |=> !rsp_valid); // R7

    AST_OWNER_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_pass_dirty) |-> rsp_data); // R9

    AST_VICTIM_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> req_valid); // R12

    AST_HIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && loc_ready && loc_hit) |=> !req_valid); // R6

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .loc_valid      (loc_valid),
    .loc_addr       (loc_addr),
    .loc_ready      (loc_ready),
    .loc_hit        (loc_hit),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .vic_valid      (vic_valid),
    .snp_valid      (snp_valid),
    .snp_addr       (snp_addr),
    .snp_ready      (snp_ready),
    .rsp_valid      (rsp_valid),
    .rsp_data       (rsp_data),
    .rsp_pass_dirty (rsp_pass_dirty)
);

// File: tb/tb_coh_line_ctrl.sv
module tb_coh_line_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loc_valid = 1'b0;
    logic [2:0] loc_op = '0;
    logic [7:0] loc_addr = '0;
    logic       loc_ready, loc_hit;
    logic       req_valid;
    logic [2:0] req_type;
    logic [7:0] req_addr;
    logic       vic_valid, vic_dirty;
    logic [7:0] vic_addr;
    logic       cmp_valid = 1'b0, cmp_pass_dirty = 1'b0, cmp_is_shared = 1'b0;
    logic       snp_valid = 1'b0;
    logic [2:0] snp_type = '0;
    logic [7:0] snp_addr = '0;
    logic       snp_ready, rsp_valid, rsp_data, rsp_pass_dirty, rsp_is_shared;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_line_ctrl #(.ADDR_W(8), .DEPTH(16)) dut (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(loc_valid), .loc_op(loc_op), .loc_addr(loc_addr),
        .loc_ready(loc_ready), .loc_hit(loc_hit),
        .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
        .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_addr(vic_addr),
        .cmp_valid(cmp_valid), .cmp_pass_dirty(cmp_pass_dirty), .cmp_is_shared(cmp_is_shared),
        .snp_valid(snp_valid), .snp_type(snp_type), .snp_addr(snp_addr),
        .snp_ready(snp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_pass_dirty(rsp_pass_dirty), .rsp_is_shared(rsp_is_shared)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] addr;
        logic       hit;
        logic [2:0] rq;
        logic       pd;
        logic       sh;
        logic [1:0] vic;   // 0 none, 1 clean eviction, 2 write-back
        logic [7:0] vaddr;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 8'h01, 1'b0, 3'd0, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd3, 8'h01, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd1, 8'h02, 1'b0, 3'd1, 1'b1, 1'b1, 2'd0, 8'h00},
        '{3'd0, 8'h03, 1'b0, 3'd0, 1'b1, 1'b1, 2'd0, 8'h00},
        '{3'd0, 8'h04, 1'b0, 3'd0, 1'b0, 1'b1, 2'd0, 8'h00},
        '{3'd3, 8'h04, 1'b0, 3'd4, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd2, 8'h05, 1'b0, 3'd2, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd2, 8'h05, 1'b0, 3'd2, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd3, 8'h06, 1'b0, 3'd3, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd4, 8'h07, 1'b0, 3'd5, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd1, 8'h09, 1'b0, 3'd1, 1'b0, 1'b1, 2'd0, 8'h00},
        '{3'd4, 8'h09, 1'b0, 3'd5, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd0, 8'h01, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd1, 8'h08, 1'b0, 3'd1, 1'b1, 1'b0, 2'd0, 8'h00},
        '{3'd0, 8'h0A, 1'b0, 3'd0, 1'b0, 1'b0, 2'd0, 8'h00},
        '{3'd0, 8'h1A, 1'b0, 3'd0, 1'b0, 1'b0, 2'd1, 8'h0A},
        '{3'd0, 8'h11, 1'b0, 3'd0, 1'b0, 1'b0, 2'd2, 8'h01}
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic local_op(input logic [2:0] op, input logic [7:0] a, input logic ehit,
                            input logic [2:0] erq, input logic [1:0] evic, input logic [7:0] eva);
        string rt;
        rt = (op >= 3'd3) ? "R5" : "R2";
        loc_valid = 1'b1; loc_op = op; loc_addr = a;
        #1;
        chk("R11", "loc_ready", loc_ready, 1);
        chk((ehit && op >= 3'd3) ? "R6" : rt, "loc_hit", loc_hit, ehit);
        @(posedge clk); @(negedge clk);
        loc_valid = 1'b0;
        chk(rt, "req_valid", req_valid, !ehit);
        if (!ehit) begin
            chk(rt, "req_type", req_type, erq);
            chk(rt, "req_addr", req_addr, a);
        end
        chk("R12", "vic_valid", vic_valid, evic != 2'd0);
        if (evic != 2'd0) begin
            chk("R12", "vic_dirty", vic_dirty, evic == 2'd2);
            chk("R12", "vic_addr", vic_addr, eva);
        end
    endtask

    task automatic complete(input logic pd, input logic sh);
        cmp_valid = 1'b1; cmp_pass_dirty = pd; cmp_is_shared = sh;
        @(posedge clk); @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic snoop(input logic [2:0] t, input logic [7:0] a, input logic ed,
                         input logic epd, input logic esh, input string rt);
        snp_valid = 1'b1; snp_type = t; snp_addr = a;
        #1;
        chk(rt, "snp_ready", snp_ready, 1);
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b0;
        chk(rt, "rsp_valid", rsp_valid, 1);
        chk(rt, "rsp_data", rsp_data, ed);
        chk(rt, "rsp_pass_dirty", rsp_pass_dirty, epd);
        chk(rt, "rsp_is_shared", rsp_is_shared, esh);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "req_valid", req_valid, 0);
        chk("R1", "vic_valid", vic_valid, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "loc_ready", loc_ready, 1);
        chk("R1", "snp_ready", snp_ready, 1);
        @(negedge clk);
        snoop(3'd0, 8'h00, 0, 0, 0, "R1");

        // table walk: local accesses and fills
        for (int i = 0; i < NVEC; i++) begin
            local_op(VECS[i].op, VECS[i].addr, VECS[i].hit, VECS[i].rq, VECS[i].vic, VECS[i].vaddr);
            if (!VECS[i].hit) complete(VECS[i].pd, VECS[i].sh);
        end

        // R3: ReadShared with both flags gave SharedDirty at 0x03
        snoop(3'd5, 8'h03, 1, 1, 1, "R3");
        local_op(3'd3, 8'h03, 0, 3'd4, 2'd0, 8'h00);
        complete(0, 0);
        // R3: not-shared-dirty fill with both flags gave UniqueDirty at 0x02; R10 clean keeps unique
        snoop(3'd5, 8'h02, 1, 1, 1, "R3");
        local_op(3'd3, 8'h02, 1, 3'd0, 2'd0, 8'h00);
        // R10 second CleanShared on now-clean line returns no data
        snoop(3'd5, 8'h02, 1, 1, 1, "R10");
        snoop(3'd5, 8'h02, 0, 0, 1, "R10");
        // R8 ReadOnce snoop keeps UniqueClean at 0x11
        snoop(3'd0, 8'h11, 1, 0, 1, "R8");
        local_op(3'd3, 8'h11, 1, 3'd0, 2'd0, 8'h00);
        // R8 ReadShared snoop turns UniqueDirty to SharedDirty at 0x04
        snoop(3'd1, 8'h04, 1, 0, 1, "R8");
        snoop(3'd5, 8'h04, 1, 1, 1, "R8");
        local_op(3'd3, 8'h04, 0, 3'd4, 2'd0, 8'h00);
        complete(0, 0);
        // R9 invalidating snoops
        snoop(3'd2, 8'h06, 1, 1, 0, "R9");
        snoop(3'd0, 8'h06, 0, 0, 0, "R9");
        snoop(3'd3, 8'h07, 1, 1, 0, "R9");
        snoop(3'd0, 8'h07, 0, 0, 0, "R9");
        snoop(3'd4, 8'h09, 1, 1, 0, "R9");
        snoop(3'd4, 8'h1A, 0, 0, 0, "R9");
        snoop(3'd0, 8'h1A, 0, 0, 0, "R9");
        // R4 one-shot fills never allocated 0x05; R7 absent line
        snoop(3'd0, 8'h05, 0, 0, 0, "R4");
        snoop(3'd1, 8'h25, 0, 0, 0, "R7");

        // R11 hazard window
        local_op(3'd0, 8'h0B, 0, 3'd0, 2'd0, 8'h00);
        snp_valid = 1'b1; snp_type = 3'd0; snp_addr = 8'h0B;
        loc_valid = 1'b1; loc_op = 3'd0; loc_addr = 8'h0B;
        #1;
        chk("R11", "snp_ready held", snp_ready, 0);
        chk("R11", "loc_ready same slot", loc_ready, 0);
        loc_addr = 8'h08;
        #1;
        chk("R11", "loc_ready other hit", loc_ready, 1);
        chk("R11", "loc_hit other hit", loc_hit, 1);
        loc_addr = 8'h0C;
        #1;
        chk("R11", "loc_ready second miss", loc_ready, 0);
        loc_valid = 1'b0;
        cmp_valid = 1'b1; cmp_pass_dirty = 1'b1; cmp_is_shared = 1'b0;
        @(posedge clk); @(negedge clk);
        cmp_valid = 1'b0;
        #1;
        chk("R11", "rsp_valid while held", rsp_valid, 0);
        chk("R11", "snp_ready released", snp_ready, 1);
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b0;
        chk("R11", "rsp_valid", rsp_valid, 1);
        chk("R11", "rsp_data", rsp_data, 1);
        chk("R11", "rsp_is_shared", rsp_is_shared, 1);

        // R13 snoop wins over local access to the same slot
        snp_valid = 1'b1; snp_type = 3'd2; snp_addr = 8'h08;
        loc_valid = 1'b1; loc_op = 3'd0; loc_addr = 8'h18;
        #1;
        chk("R13", "snp_ready", snp_ready, 1);
        chk("R13", "loc_ready", loc_ready, 0);
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b0; loc_valid = 1'b0;
        chk("R13", "req_valid", req_valid, 0);
        chk("R13", "rsp_data", rsp_data, 1);
        chk("R13", "rsp_pass_dirty", rsp_pass_dirty, 1);
        local_op(3'd0, 8'h18, 0, 3'd0, 2'd0, 8'h00);
        complete(0, 0);
        snoop(3'd0, 8'h18, 1, 0, 1, "R13");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule